// File: doc/BRIEF.md
# Push-Button Debouncer with Saturating Hold Counter

This block turns a bouncing, clock-asynchronous push-button line into a clean level that the rest of the chip can use. The raw line first goes through a chain of flip-flops so that later logic sees only values that are in step with the clock. A hold counter then counts the cycles for which that synchronized value has stayed high. The conditioned output rises only after the counter has filled up.

The button is active high. Press and release are treated differently. A press must be held without a break for the full count before the output rises. A release needs only one low synchronized sample to clear the counter and drop the output in that same cycle. Making pulses from edges and counting presses are left to blocks further down the chain.

The length of the synchronizer chain and the width of the counter are parameters. The defaults are 2 stages and 20 bits, which gives about 21 ms of qualification at 50 MHz.

Top module: `btn_debounce`

## Requirements
- R1: A change on `btn_i` reaches the evaluation logic after exactly `SYNC_STAGES` rising clock edges. No logic acts on the raw line before that.
- R2: While the synchronized input is high, the counter steps up by one per cycle until it reaches 2^`CNT_W`-1. It then holds that value and does not wrap, so `level_o` stays high for as long as the press lasts.
- R3: A single low synchronized sample clears the counter to zero. `level_o` is 0 in that cycle; release is not debounced.
- R4: `level_o` is 1 exactly when the synchronized input is high and the counter is at its maximum. After a steady press, the first high cycle comes `SYNC_STAGES` + 2^`CNT_W` - 1 edges after the first edge that samples the press.
- R5: A run of r consecutive high samples of `btn_i` drives `level_o` high for r - 2^`CNT_W` + 1 cycles if r >= 2^`CNT_W`, and never if r is shorter. Bounces shorter than the full count are therefore rejected.
- R6: `rst_ni` low clears the synchronizer stages and the counter at once, without waiting for a clock edge. `level_o` is 0 during reset and stays 0 after release until a fresh full count completes.
- R7: No combinational path runs from `btn_i` to `level_o`. A change on `btn_i` between clock edges leaves `level_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| btn_i | input | 1 | Raw button line, active high, asynchronous |
| level_o | output | 1 | Conditioned button level |

## Verification
The hardest cases to reach are the exact qualification boundary and a release right after saturation. In the first, a run one sample too short must stay silent while a run of exactly the full count produces a single high cycle. In the second, the output must drop on the first low synchronized sample. The bench uses a narrow counter and sweeps the lengths of high runs from one sample past the threshold, with low gaps of one and more samples between runs. An arithmetic run-length model shifted by the synchronizer depth predicts every cycle. An asynchronous reset during a saturated press, and a drop of the raw line between edges, complete the stimulus.

// File: rtl/btn_debounce_pkg.sv
package btn_debounce_pkg;
  localparam int unsigned DEF_SYNC_STAGES = 2;
  localparam int unsigned DEF_CNT_W       = 20;

  // all-ones value of a width-w counter, as a 32-bit quantity
  function automatic int unsigned full_count(input int unsigned w);
    return (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
  endfunction
endpackage

// File: rtl/btn_sync_chain.sv
module btn_sync_chain #(
  parameter int unsigned STAGES = btn_debounce_pkg::DEF_SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  generate
    if (STAGES <= 1) begin : g_single
      logic stage_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q <= 1'b0;
        else         stage_q <= d_i;
      end
      assign q_o = stage_q;
    end else begin : g_chain
      logic [STAGES-1:0] stage_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q <= '0;
        else         stage_q <= {stage_q[STAGES-2:0], d_i};
      end
      assign q_o = stage_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/btn_hold_counter.sv
module btn_hold_counter #(
  parameter int unsigned CNT_W = btn_debounce_pkg::DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             level_o
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             full;

  assign full = (cnt_q == CntMax);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!hold_i) cnt_q <= '0;
    else if (!full)   cnt_q <= cnt_q + CNT_W'(1);
  end

  // gated by the registered sync bit so release shows in the same cycle
  assign level_o = hold_i & full;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/btn_debounce.sv
module btn_debounce #(
  parameter int unsigned SYNC_STAGES = btn_debounce_pkg::DEF_SYNC_STAGES,
  parameter int unsigned CNT_W       = btn_debounce_pkg::DEF_CNT_W
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_i,
  output logic level_o
);
  logic             sync_q;
  logic [CNT_W-1:0] cnt_q;

  btn_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (btn_i),
    .q_o   (sync_q)
  );

  btn_hold_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (sync_q),
    .cnt_o  (cnt_q),
    .level_o(level_o)
  );
endmodule

// File: rtl/btn_debounce_chk.sv
module btn_debounce_chk #(
  parameter int unsigned CNT_W = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sync_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             level_o
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  // R3
  clear_on_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_q |=> cnt_q == '0);

  // R2
  count_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_q && cnt_q != CntMax) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  // R2
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_q && cnt_q == CntMax) |=> cnt_q == CntMax);

  // R4
  level_needs_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o |-> (sync_q && cnt_q == CntMax));

  // R4
  level_when_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_q && cnt_q == CntMax) |-> level_o);

  // R5
  rise_after_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(level_o) |-> $past(cnt_q) == CntMax - CNT_W'(1));
endmodule

bind btn_debounce btn_debounce_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .sync_q (sync_q),
  .cnt_q  (cnt_q),
  .level_o(level_o)
);

// File: tb/tb_btn_debounce.sv
module tb_btn_debounce;
  localparam int SYNC = 2;
  localparam int CW   = 4;
  localparam int FULL = 1 << CW;  // high samples needed to assert

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btn = 1'b0;
  logic level;

  int errors = 0;
  int checks = 0;
  int cur_run = 0;
  int rp [SYNC];
  bit done = 1'b0;

  always #2 clk = ~clk;

  btn_debounce #(.SYNC_STAGES(SYNC), .CNT_W(CW)) dut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .btn_i  (btn),
    .level_o(level)
  );

  task automatic check(input logic exp, input string tag);
    checks++;
    if (level !== exp) begin
      errors++;
      $display("FAIL %s: level_o=%b expected %b at %0t", tag, level, exp, $time);
    end
  endtask

  task automatic model_clear();
    cur_run = 0;
    for (int i = 0; i < SYNC; i++) rp[i] = 0;
  endtask

  // called at a negedge; drives, clocks, checks at next negedge
  task automatic step(input logic b, input string tag);
    btn = b;
    @(posedge clk);
    cur_run = b ? cur_run + 1 : 0;
    for (int i = SYNC - 1; i > 0; i--) rp[i] = rp[i-1];
    rp[0] = cur_run;
    @(negedge clk);
    check(rp[SYNC-1] >= FULL, tag);
  endtask

  initial begin
    int lat;
    model_clear();
    repeat (3) @(negedge clk);
    check(1'b0, "R6 reset state");
    rst_n = 1'b1;

    // R1/R4: latency from first high sample to first high output
    lat = 0;
    btn = 1'b1;
    while (level !== 1'b1 && lat < 100) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    checks++;
    if (lat != SYNC + FULL - 1) begin
      errors++;
      $display("FAIL R1: latency=%0d expected %0d", lat, SYNC + FULL - 1);
    end
    cur_run = lat;
    for (int i = 0; i < SYNC; i++) rp[i] = lat - i;

    // R2: long hold stays high, no wrap
    for (int i = 0; i < 3 * FULL; i++) step(1'b1, "R2 saturated hold");

    // R7: raw drop between edges leaves output unchanged
    btn = 1'b0;
    #1;
    check(1'b1, "R7 no comb path");
    #0.5;
    btn = 1'b1;
    @(negedge clk);
    cur_run++;
    for (int i = SYNC - 1; i > 0; i--) rp[i] = rp[i-1];
    rp[0] = cur_run;
    check(1'b1, "R7 after glitch");

    // R3: single low sample drops output
    step(1'b0, "R3 single low");
    for (int i = 0; i < SYNC + 1; i++) step(1'b1, "R3 release");
    for (int i = 0; i < FULL + 4; i++) step(1'b1, "R4 requalify");

    // R5: sweep of high-run lengths with varying gaps
    for (int r = 1; r <= FULL + 4; r++) begin
      for (int g = 1; g <= 3; g++) begin
        for (int k = 0; k < g; k++) step(1'b0, "R3 gap");
        for (int k = 0; k < r; k++) step(1'b1, "R5 run sweep");
      end
    end
    for (int k = 0; k < SYNC + 2; k++) step(1'b0, "R3 tail");

    // R6: async reset during saturated press
    for (int i = 0; i < FULL + SYNC + 2; i++) step(1'b1, "R4 before reset");
    check(1'b1, "R6 pre-reset high");
    #1;
    rst_n = 1'b0;
    #0.5;
    check(1'b0, "R6 async clear");
    repeat (2) @(negedge clk);
    check(1'b0, "R6 held in reset");
    model_clear();
    rst_n = 1'b1;
    for (int i = 0; i < FULL + SYNC + 3; i++) step(1'b1, "R6 fresh count");
    step(1'b0, "R3 final");
    step(1'b0, "R3 final");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule